// File: doc/BRIEF.md
# TDM Frame Slot Tracker

This block is the channel timing core that the transmit and receive halves of a time-division-multiplexed serial port share. It runs on the serial bit clock and watches a frame sync input. Once a frame sync is seen, it waits a programmable number of bit clocks and then counts channel slots of a fixed bit width. Counting runs until the last slot of a 128-slot frame ends. For every bit clock it reports the current slot index, a strobe on the first bit and a strobe on the last bit of each slot, and a marker on the very first data bit of the frame. It also raises a flag when the current slot lies inside a programmable active window.

Everything is set through one 16-bit configuration word. The word holds an enable, a start delay, a window length in steps of eight channels, and a window start channel. A frame sync samples the delay and window fields, so the frame in progress keeps its settings when the word changes. Frames may follow each other with no gap. A frame sync that comes before the current frame has ended restarts the timing at once.

Top module: `tdm_slot_tracker`

## Requirements
- R1: While reset is asserted and after it is released, with the configuration word at 0x0000, all strobes and flags are low and the slot index is 0.
- R2: When the enable bit (configuration bit 11) is 0, the active flag, both slot strobes, the first-bit marker and the in-window flag stay low and the slot index is 0, whatever the frame sync does. Clearing the bit in the middle of a frame stops all activity in that same cycle, and activity stays stopped until the next frame sync with the bit set.
- R3: The start delay D is held in configuration bits [15:12]. The first data bit of slot 0 falls D bit clocks after the cycle in which the frame sync is high. With D = 0 it falls in the frame sync cycle itself, and D = 15 is supported.
- R4: Each slot lasts SLOT_BITS bit clocks. The slot-start strobe is high on the slot's first bit and the slot-last strobe on its final bit. The slot index runs 0, 1, 2 and so on, one step per slot.
- R5: After the final bit of slot 127, the active flag and all strobes stay low until the next frame sync.
- R6: With window start O in bits [6:0] and length code S in bits [10:7], the in-window flag is high exactly when a slot is active and its index k satisfies O <= k < O + 8*(S+1). Slots beyond 127 never occur.
- R7: A frame sync that arrives during the delay or during slot counting restarts the delay and the counting from slot 0, bit 0.
- R8: Changes to the delay, window start or window length fields during a frame have no effect on that frame. They apply from the next frame sync onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 16 | Configuration word: [6:0] window start, [10:7] window length code, [11] enable, [15:12] start delay |
| fsync_i | input | 1 | Frame sync, sampled every bit clock |
| active_o | output | 1 | Current bit clock carries a data bit of the frame |
| slot_idx_o | output | 7 | Index of the current slot, 0 when not active |
| slot_start_o | output | 1 | First bit of a slot |
| slot_last_o | output | 1 | Final bit of a slot |
| first_bit_o | output | 1 | First bit of slot 0 |
| in_window_o | output | 1 | Current slot lies inside the active window |

## Verification
An error in the delay or bit counters shows up within the same frame. The first-bit marker lands on the wrong cycle relative to the frame sync, or a slot strobe lands on the wrong bit. Both are visible within at most sixteen bit clocks of the sync. An error in the slot counter or in the held window bounds shows up as a wrong slot index or a wrong in-window flag on the next slot-start strobe. A failed restart shows up on the first bit clock after an early sync. For these reasons the bench compares every output on every bit clock against a position computed from the sync cycle alone.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

    localparam int CFG_W  = 16;
    localparam int OFF_W  = 7;
    localparam int SIZE_W = 4;
    localparam int DLY_W  = 4;
    localparam int GRAN   = 8;   // channels per window length step

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

    // Field order is the word layout, MSB first
    typedef struct packed {
        logic [DLY_W-1:0]  dly;
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [OFF_W-1:0]  off;
    } cfg_t;

endpackage

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [OFF_W-1:0]  off_o,
    output logic [SIZE_W-1:0] size_o
);

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [SIZE_W-1:0] size;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (take_i) begin
            win_d.off  = off_i;
            win_d.size = size_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // A frame sync cycle already runs with the new window
    assign off_o  = take_i ? off_i  : win_q.off;
    assign size_o = take_i ? size_i : win_q.size;

endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
    import tdm_slot_pkg::*;
#(
    parameter int SLOT_BITS   = 8,
    parameter int FRAME_SLOTS = 128,
    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1,
    localparam int IDX_W = $clog2(FRAME_SLOTS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             fsync_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             active_o,
    output logic [IDX_W-1:0] slot_o,
    output logic [BIT_W-1:0] bit_o
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_SLOTS - 1);

    typedef struct packed {
        phase_e           ph;
        logic [DLY_W-1:0] rem;
        logic [BIT_W-1:0] bitc;
        logic [IDX_W-1:0] slot;
    } st_t;

    st_t st_q, st_d, cur;

    always_comb begin
        // Position of the present cycle: stored position unless overridden
        cur = st_q;
        if (!en_i) begin
            cur.ph   = PH_IDLE;
            cur.rem  = '0;
            cur.bitc = '0;
            cur.slot = '0;
        end else if (fsync_i) begin
            cur.ph   = (dly_i == '0) ? PH_DATA : PH_DELAY;
            cur.rem  = dly_i;
            cur.bitc = '0;
            cur.slot = '0;
        end

        // Position of the following cycle
        st_d = cur;
        case (cur.ph)
            PH_DELAY: begin
                if (cur.rem == DLY_W'(1)) begin
                    st_d.ph   = PH_DATA;
                    st_d.rem  = '0;
                    st_d.bitc = '0;
                    st_d.slot = '0;
                end else begin
                    st_d.rem = cur.rem - 1'b1;
                end
            end
            PH_DATA: begin
                if (cur.bitc == LAST_BIT) begin
                    st_d.bitc = '0;
                    if (cur.slot == LAST_SLOT) begin
                        st_d.ph   = PH_IDLE;
                        st_d.slot = '0;
                    end else begin
                        st_d.slot = cur.slot + 1'b1;
                    end
                end else begin
                    st_d.bitc = cur.bitc + 1'b1;
                end
            end
            default: st_d = cur;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.rem  <= '0;
            st_q.bitc <= '0;
            st_q.slot <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (cur.ph == PH_DATA);
    assign slot_o   = active_o ? cur.slot : '0;
    assign bit_o    = active_o ? cur.bitc : '0;

endmodule

// File: rtl/tdm_window_cmp.sv
module tdm_window_cmp
    import tdm_slot_pkg::*;
#(
    parameter int FRAME_SLOTS = 128,
    localparam int IDX_W = $clog2(FRAME_SLOTS),
    localparam int CMP_W = OFF_W + 2
)(
    input  logic              active_i,
    input  logic [IDX_W-1:0]  slot_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              in_win_o
);

    logic [CMP_W-1:0] lo, len, hi, k;

    always_comb begin
        lo  = CMP_W'(off_i);
        len = (CMP_W'(size_i) + 1'b1) * CMP_W'(GRAN);
        hi  = lo + len;
        k   = CMP_W'(slot_i);
        in_win_o = active_i && (k >= lo) && (k < hi);
    end

endmodule

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
    import tdm_slot_pkg::*;
#(
    parameter int SLOT_BITS   = 8,
    parameter int FRAME_SLOTS = 128
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cfg_i,
    input  logic        fsync_i,
    output logic        active_o,
    output logic [6:0]  slot_idx_o,
    output logic        slot_start_o,
    output logic        slot_last_o,
    output logic        first_bit_o,
    output logic        in_window_o
);

    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam int IDX_W = $clog2(FRAME_SLOTS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    cfg_t              cfg;
    logic              take;
    logic [OFF_W-1:0]  win_off;
    logic [SIZE_W-1:0] win_size;
    logic              act;
    logic [IDX_W-1:0]  slot;
    logic [BIT_W-1:0]  bitc;
    logic              in_win;

    assign cfg  = cfg_t'(cfg_i);
    assign take = cfg.en && fsync_i;

    tdm_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .off_i  (cfg.off),
        .size_i (cfg.size),
        .off_o  (win_off),
        .size_o (win_size)
    );

    tdm_slot_counter #(
        .SLOT_BITS   (SLOT_BITS),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg.en),
        .fsync_i  (fsync_i),
        .dly_i    (cfg.dly),
        .active_o (act),
        .slot_o   (slot),
        .bit_o    (bitc)
    );

    tdm_window_cmp #(
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_win (
        .active_i (act),
        .slot_i   (slot),
        .off_i    (win_off),
        .size_i   (win_size),
        .in_win_o (in_win)
    );

    assign active_o     = act;
    assign slot_idx_o   = 7'(slot);
    assign slot_start_o = act && (bitc == '0);
    assign slot_last_o  = act && (bitc == LAST_BIT);
    assign first_bit_o  = act && (bitc == '0) && (slot == '0);
    assign in_window_o  = in_win;

endmodule

// File: rtl/tdm_slot_tracker_chk.sv
module tdm_slot_tracker_chk #(
    parameter int FRAME_SLOTS = 128
)(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_i,
    input logic        fsync_i,
    input logic        active_o,
    input logic [6:0]  slot_idx_o,
    input logic        slot_start_o,
    input logic        slot_last_o,
    input logic        first_bit_o,
    input logic        in_window_o
);

    localparam logic [6:0] LAST_SLOT = 7'(FRAME_SLOTS - 1);

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i[11] |-> !active_o && !slot_start_o && !slot_last_o && !first_bit_o && !in_window_o);

    assert_zero_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_i && cfg_i[11] && cfg_i[15:12] == 4'd0) |-> first_bit_o);

    assert_start_needs_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start_o || slot_last_o) |-> active_o);

    assert_slot_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_last_o && slot_idx_o != LAST_SLOT) |=>
            (fsync_i || !cfg_i[11] || (slot_start_o && slot_idx_o == $past(slot_idx_o) + 7'd1)));

    assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_last_o && slot_idx_o == LAST_SLOT) |=> (fsync_i || !active_o));

    assert_window_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_window_o |-> active_o);

endmodule

bind tdm_slot_tracker tdm_slot_tracker_chk #(.FRAME_SLOTS(FRAME_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_i),
    .fsync_i      (fsync_i),
    .active_o     (active_o),
    .slot_idx_o   (slot_idx_o),
    .slot_start_o (slot_start_o),
    .slot_last_o  (slot_last_o),
    .first_bit_o  (first_bit_o),
    .in_window_o  (in_window_o)
);

// File: tb/tdm_slot_tracker_tb.sv
`timescale 1ns/1ps
module tdm_slot_tracker_tb;

    localparam int CLK_NS = 8;
    localparam int SB     = 8;
    localparam int NSLOT  = 128;
    localparam int FLEN   = SB * NSLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_i = 16'h0000;
    logic        fsync_i = 1'b0;
    logic        active_o, slot_start_o, slot_last_o, first_bit_o, in_window_o;
    logic [6:0]  slot_idx_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    tdm_slot_tracker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_i        (cfg_i),
        .fsync_i      (fsync_i),
        .active_o     (active_o),
        .slot_idx_o   (slot_idx_o),
        .slot_start_o (slot_start_o),
        .slot_last_o  (slot_last_o),
        .first_bit_o  (first_bit_o),
        .in_window_o  (in_window_o)
    );

    function automatic logic [15:0] mk(input int dly, input bit en, input int sz, input int off);
        return {4'(dly), en, 4'(sz), 7'(off)};
    endfunction

    task automatic compare(input logic [11:0] exp, input string req, input int k);
        logic [11:0] act;
        act = {active_o, slot_idx_o, slot_start_o, slot_last_o, first_bit_o, in_window_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h (act,idx,start,last,first,win)",
                     req, k, act, exp);
        end
    endtask

    // Drives a frame sync with c0 in cycle 0, switches to c1 at cycle chg,
    // checks every cycle against a position derived from the sync cycle.
    task automatic run_frame(input logic [15:0] c0, input int n, input int chg,
                             input logic [15:0] c1, input string req);
        int  d   = int'(c0[15:12]);
        int  off = int'(c0[6:0]);
        int  len = 8 * (int'(c0[10:7]) + 1);
        bit  dead = !c0[11];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fsync_i = (k == 0);
            if (k == 0)   cfg_i = c0;
            if (k == chg) begin
                cfg_i = c1;
                if (!c1[11]) dead = 1'b1;
            end
            #2;
            begin
                int p = k - d;
                bit a = !dead && p >= 0 && p < FLEN;
                int s = a ? p / SB : 0;
                int b = a ? p % SB : 0;
                logic [11:0] e;
                e = {a, 7'(s), a && b == 0, a && b == SB-1, a && p == 0,
                     a && s >= off && s < off + len};
                compare(e, req, k);
            end
        end
        @(negedge clk);
        fsync_i = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        compare(12'h000, "R1 in reset", 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            #2 compare(12'h000, "R1 after reset", 0);
        end
    endtask

    task automatic t_disabled();
        // Syncs with enable bit 11 clear: nothing happens
        run_frame(mk(0, 0, 15, 0), 40, -1, 16'h0, "R2 disabled sync");
        run_frame(mk(3, 0, 0, 0), 20, -1, 16'h0, "R2 disabled sync dly3");
    endtask

    task automatic t_delay_zero();
        run_frame(mk(0, 1, 0, 0), FLEN + 6, -1, 16'h0, "R3 R4 R5 R6 delay 0");
    endtask

    task automatic t_delay_max();
        run_frame(mk(15, 1, 2, 5), FLEN + 20, -1, 16'h0, "R3 R4 R5 R6 delay 15");
    endtask

    task automatic t_window_edges();
        // Window reaching past the last slot is cut at slot 127
        run_frame(mk(2, 1, 15, 100), FLEN + 4, -1, 16'h0, "R6 window clipped");
        run_frame(mk(1, 1, 15, 0), FLEN + 3, -1, 16'h0, "R6 full window");
        run_frame(mk(4, 1, 3, 127), FLEN + 6, -1, 16'h0, "R6 last slot only");
    endtask

    task automatic t_early_sync();
        // Each new sync lands mid-frame (R7)
        run_frame(mk(5, 1, 1, 3), 300, -1, 16'h0, "R7 first frame");
        run_frame(mk(0, 1, 0, 2), 9, -1, 16'h0, "R7 resync in slot 1");
        run_frame(mk(7, 1, 4, 10), 3, -1, 16'h0, "R7 resync in delay");
        run_frame(mk(1, 1, 0, 0), 200, -1, 16'h0, "R7 resync again");
    endtask

    task automatic t_cfg_mid_frame();
        // New delay and window written mid-frame must not move this frame (R8)
        run_frame(mk(2, 1, 0, 4), FLEN + 4, 30, mk(9, 1, 7, 60), "R8 hold window");
        // The next sync picks the new value up
        run_frame(mk(9, 1, 7, 60), 400, -1, 16'h0, "R8 new value applied");
    endtask

    task automatic t_disable_mid_frame();
        run_frame(mk(1, 1, 15, 0), 120, 50, mk(1, 0, 15, 0), "R2 disable mid-frame");
        run_frame(mk(0, 1, 0, 0), 16, -1, 16'h0, "R2 re-enable");
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled();
        t_delay_zero();
        t_delay_max();
        t_window_edges();
        t_early_sync();
        t_cfg_mid_frame();
        t_disable_mid_frame();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule